// File: doc/BRIEF.md
# Multi-Stream Sample Alignment Merger

This block gathers the samples of one time step from five independent packetized input streams and releases them together as a single merged packet. Three narrow streams each deliver four 28-bit samples per time step, tagged with a 2-bit sub-channel number. Two wide streams each deliver two 34-bit samples, tagged with a 1-bit sub-channel number. The streams may arrive with arbitrary skew relative to each other. Every sample is parked in its own holding register, and each holding register has an arrival flag.

Once all sixteen flags are set, the block serializes the time step onto one 34-bit output stream. The stream carries a 4-bit channel number, valid, start-of-packet and end-of-packet. The output has no ready signal, so the consumer takes one word on every cycle in which valid is high. The arrival flags of each input group are released while the packet is still being sent, on the edge that emits that group's final channel. An early stream can therefore already deliver the next time step. A sample that would overwrite a channel still waiting to be sent raises a sticky error flag.

Top module: `sample_aligner`

## Requirements
- R1: While `rst` is high at a rising edge, the edge clears `outValid`, `outSop`, `outEop`, `outChan`, `outData` and `overlapErr` to zero and discards all held samples. After reset, no packet leaves until all sixteen channels have been delivered again.
- R2: A sample on narrow stream g (0..2) with sub-channel c (0..3) is emitted on output channel 4g+c. A sample on wide stream w (0..1) with sub-channel c (0..1) is emitted on output channel 12+2w+c. The emitted value is the last value held for that channel.
- R3: No output word is valid while any of the sixteen channels lacks a sample. Call the rising edge that captures the last missing sample edge 1. The channel-0 word is presented starting at edge 2.
- R4: A packet is sixteen consecutive valid words that carry channels 0 to 15 in ascending order.
- R5: `outSop` is high only together with channel 0, and `outEop` only together with channel 15. The word after channel 15 has valid low, so one packet spans 17 cycles. Whenever valid is low, `outChan` and `outData` are zero.
- R6: A narrow sample occupies bits 33:6 of `outData` and bits 5:0 are zero. A wide sample fills all 34 bits.
- R7: A group's arrival flags are cleared on the edge that emits its last channel (3, 7, 11, 13 or 15). A sample captured on that edge or later counts toward the next packet without raising an error. The next packet may start on the edge right after the 17th cycle.
- R8: A sample captured during an emission into a channel whose group has not yet been released sets `overlapErr`, visible after the capturing edge. The sample still replaces the held value.
- R9: `overlapErr` stays high until reset, including across later error-free packets.
- R10: Outside an emission, a repeated sample for a channel that is already held replaces the held value without raising an error. Only the last value is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| narValid | input | 3 | Sample valid, one bit per narrow stream |
| narChan | input | 3x2 | Sub-channel number per narrow stream |
| narData | input | 3x28 | Sample value per narrow stream |
| wideValid | input | 2 | Sample valid, one bit per wide stream |
| wideChan | input | 2x1 | Sub-channel number per wide stream |
| wideData | input | 2x34 | Sample value per wide stream |
| outValid | output | 1 | Output word valid |
| outSop | output | 1 | First word of a packet |
| outEop | output | 1 | Last word of a packet |
| outChan | output | 4 | Output channel number |
| outData | output | 34 | Output sample, narrow samples left-aligned and zero-padded |
| overlapErr | output | 1 | Sticky flag for a sample that lands on a channel still waiting to be sent |

## Verification
A flag that is set wrongly or released too early makes a packet leave one or more cycles early or late, or never. A stale held value shows up as a wrong `outData` word within the 17 cycles of the packet that carries it. A release on the wrong edge shows up either as a refill that is silently lost, which stalls the next packet indefinitely, or as a spurious `overlapErr` one edge after the refill. Because the reference model is compared on every clock, each of these appears at the ports on the first cycle where it diverges, at most one packet after the fault.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int unsigned NAR_GRP    = 3;
  localparam int unsigned NAR_PER    = 4;
  localparam int unsigned NAR_W      = 28;
  localparam int unsigned WIDE_GRP   = 2;
  localparam int unsigned WIDE_PER   = 2;
  localparam int unsigned WIDE_W     = 34;

  localparam int unsigned NAR_CH     = NAR_GRP * NAR_PER;
  localparam int unsigned NUM_CH     = NAR_CH + WIDE_GRP * WIDE_PER;
  localparam int unsigned NUM_GRP    = NAR_GRP + WIDE_GRP;
  localparam int unsigned OUT_W      = WIDE_W;
  localparam int unsigned PAD_W      = OUT_W - NAR_W;
  localparam int unsigned CH_W       = $clog2(NUM_CH);
  localparam int unsigned NAR_SEL_W  = $clog2(NAR_PER);
  localparam int unsigned WIDE_SEL_W = $clog2(WIDE_PER);
  localparam int unsigned SLOT_W     = $clog2(NUM_CH + 1);

  // Strobes from control to datapath for the coming edge.
  typedef struct packed {
    logic               emit;
    logic               first;
    logic               last;
    logic [CH_W-1:0]    idx;
    logic [NUM_GRP-1:0] freeGrp;
    logic               busy;
  } strobe_t;

  function automatic int unsigned grpOf(int unsigned ch);
    if (ch < NAR_CH) return ch / NAR_PER;
    return NAR_GRP + (ch - NAR_CH) / WIDE_PER;
  endfunction

  function automatic int unsigned grpLast(int unsigned g);
    if (g < NAR_GRP) return g * NAR_PER + NAR_PER - 1;
    return NAR_CH + (g - NAR_GRP) * WIDE_PER + WIDE_PER - 1;
  endfunction
endpackage

// File: rtl/sa_ctrl.sv
module sa_ctrl
  import sa_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    allArrived,
  output strobe_t stb
);
  logic              busy;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    stb      = '0;
    stb.busy = busy;
    if (!busy) begin
      if (allArrived) begin
        stb.emit  = 1'b1;
        stb.first = 1'b1;
        stb.idx   = '0;
      end
    end else if (slot < SLOT_W'(NUM_CH)) begin
      stb.emit = 1'b1;
      stb.idx  = slot[CH_W-1:0];
      stb.last = (slot == SLOT_W'(NUM_CH - 1));
    end
    for (int g = 0; g < int'(NUM_GRP); g++) begin
      stb.freeGrp[g] = stb.emit && (stb.idx == CH_W'(grpLast(g)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (!busy) begin
      if (allArrived) begin
        busy <= 1'b1;
        slot <= SLOT_W'(1);
      end
    end else if (slot == SLOT_W'(NUM_CH)) begin
      busy <= 1'b0;
      slot <= '0;
    end else begin
      slot <= slot + 1'b1;
    end
  end

  // R4: while emitting, the slot counter stays within one packet
  assert_slot_range_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (slot >= SLOT_W'(1) && slot <= SLOT_W'(NUM_CH)));

  // R3: an emission only begins after every channel has arrived
  assert_start_needs_all_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(allArrived));
endmodule

// File: rtl/sa_datapath.sv
module sa_datapath
  import sa_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NAR_GRP-1:0]                 narValid,
  input  logic [NAR_GRP-1:0][NAR_SEL_W-1:0]  narChan,
  input  logic [NAR_GRP-1:0][NAR_W-1:0]      narData,
  input  logic [WIDE_GRP-1:0]                wideValid,
  input  logic [WIDE_GRP-1:0][WIDE_SEL_W-1:0] wideChan,
  input  logic [WIDE_GRP-1:0][WIDE_W-1:0]    wideData,
  input  strobe_t                            stb,
  output logic                               allArrived,
  output logic                               outValid,
  output logic                               outSop,
  output logic                               outEop,
  output logic [CH_W-1:0]                    outChan,
  output logic [OUT_W-1:0]                   outData,
  output logic                               overlapErr
);
  logic [OUT_W-1:0]  holdData [NUM_CH];
  logic [OUT_W-1:0]  wrData   [NUM_CH];
  logic [NUM_CH-1:0] holdFlag;
  logic [NUM_CH-1:0] wrEn;
  logic [NUM_CH-1:0] clrEn;
  logic [NUM_CH-1:0] clash;

  for (genvar ch = 0; ch < int'(NUM_CH); ch++) begin : g_ch
    localparam int unsigned GRP = grpOf(ch);
    if (ch < int'(NAR_CH)) begin : g_nar
      localparam int unsigned SUB = ch % NAR_PER;
      assign wrEn[ch]   = narValid[GRP] && (narChan[GRP] == NAR_SEL_W'(SUB));
      assign wrData[ch] = {narData[GRP], {PAD_W{1'b0}}};
    end else begin : g_wide
      localparam int unsigned WG  = GRP - NAR_GRP;
      localparam int unsigned SUB = (ch - NAR_CH) % WIDE_PER;
      assign wrEn[ch]   = wideValid[WG] && (wideChan[WG] == WIDE_SEL_W'(SUB));
      assign wrData[ch] = wideData[WG];
    end
    assign clrEn[ch] = stb.freeGrp[GRP];
    // a write into a channel still queued for the packet in flight
    assign clash[ch] = wrEn[ch] && stb.busy && holdFlag[ch] && !clrEn[ch];
  end

  // capture wins over release on the same edge
  always_ff @(posedge clk) begin
    for (int ch = 0; ch < int'(NUM_CH); ch++) begin
      if (rst) begin
        holdData[ch] <= '0;
        holdFlag[ch] <= 1'b0;
      end else if (wrEn[ch]) begin
        holdData[ch] <= wrData[ch];
        holdFlag[ch] <= 1'b1;
      end else if (clrEn[ch]) begin
        holdFlag[ch] <= 1'b0;
      end
    end
  end

  assign allArrived = &holdFlag;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      outSop     <= 1'b0;
      outEop     <= 1'b0;
      outChan    <= '0;
      outData    <= '0;
      overlapErr <= 1'b0;
    end else begin
      outValid <= stb.emit;
      outSop   <= stb.first;
      outEop   <= stb.last;
      outChan  <= stb.emit ? stb.idx : '0;
      outData  <= stb.emit ? holdData[stb.idx] : '0;
      if (|clash) overlapErr <= 1'b1;
    end
  end

  assert_sop_on_first_R5: assert property (@(posedge clk) disable iff (rst)
    outSop |-> (outValid && outChan == '0));

  assert_eop_on_final_R5: assert property (@(posedge clk) disable iff (rst)
    outEop |-> (outValid && outChan == CH_W'(NUM_CH - 1)));

  assert_gap_after_eop_R5: assert property (@(posedge clk) disable iff (rst)
    outEop |=> !outValid);

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (outChan == '0 && outData == '0));

  assert_chan_ascend_R4: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outEop) |=> (outValid && outChan == $past(outChan) + 1'b1));

  assert_pad_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && outChan < CH_W'(NAR_CH)) |-> (outData[PAD_W-1:0] == '0));

  assert_packet_opens_sop_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> outSop);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overlapErr |=> overlapErr);
endmodule

// File: rtl/sample_aligner.sv
module sample_aligner
  import sa_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NAR_GRP-1:0]                  narValid,
  input  logic [NAR_GRP-1:0][NAR_SEL_W-1:0]   narChan,
  input  logic [NAR_GRP-1:0][NAR_W-1:0]       narData,
  input  logic [WIDE_GRP-1:0]                 wideValid,
  input  logic [WIDE_GRP-1:0][WIDE_SEL_W-1:0] wideChan,
  input  logic [WIDE_GRP-1:0][WIDE_W-1:0]     wideData,
  output logic                                outValid,
  output logic                                outSop,
  output logic                                outEop,
  output logic [CH_W-1:0]                     outChan,
  output logic [OUT_W-1:0]                    outData,
  output logic                                overlapErr
);
  strobe_t stb;
  logic    allArrived;

  sa_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .allArrived (allArrived),
    .stb        (stb)
  );

  sa_datapath u_dp (
    .clk        (clk),
    .rst        (rst),
    .narValid   (narValid),
    .narChan    (narChan),
    .narData    (narData),
    .wideValid  (wideValid),
    .wideChan   (wideChan),
    .wideData   (wideData),
    .stb        (stb),
    .allArrived (allArrived),
    .outValid   (outValid),
    .outSop     (outSop),
    .outEop     (outEop),
    .outChan    (outChan),
    .outData    (outData),
    .overlapErr (overlapErr)
  );
endmodule

// File: tb/sample_aligner_bench.sv
module sample_aligner_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [2:0]       nv = '0;
  logic [2:0][1:0]  nc = '0;
  logic [2:0][27:0] nd = '0;
  logic [1:0]       wv = '0;
  logic [1:0][0:0]  wc = '0;
  logic [1:0][33:0] wd = '0;

  logic        outValid, outSop, outEop, overlapErr;
  logic [3:0]  outChan;
  logic [33:0] outData;

  sample_aligner u_sample_aligner (
    .clk(clk), .rst(rst),
    .narValid(nv), .narChan(nc), .narData(nd),
    .wideValid(wv), .wideChan(wc), .wideData(wd),
    .outValid(outValid), .outSop(outSop), .outEop(outEop),
    .outChan(outChan), .outData(outData), .overlapErr(overlapErr)
  );

  int vecCount = 0, vecFail = 0, dirCount = 0, dirFail = 0, validSeen = 0;
  logic [33:0] seenData [16];

  function automatic int grpOfB(int ch);
    return (ch < 12) ? ch / 4 : 3 + (ch - 12) / 2;
  endfunction
  function automatic int lastOfB(int g);
    return (g < 3) ? g * 4 + 3 : 12 + (g - 3) * 2 + 1;
  endfunction
  function automatic int chOf(int g, int c);
    return (g < 3) ? g * 4 + c : 12 + (g - 3) * 2 + c;
  endfunction
  function automatic logic [33:0] pat(int pkt, int ch);
    logic [33:0] v;
    v = {pkt[9:0], ch[3:0], 20'(pkt * 7919 + ch * 131)};
    return v ^ 34'h2_5A5A_5A5A;
  endfunction
  function automatic logic [33:0] expWord(int pkt, int ch);
    logic [33:0] v;
    v = pat(pkt, ch);
    return (ch < 12) ? {v[27:0], 6'b0} : v;
  endfunction

  // behavioural reference model, advanced on each rising edge
  logic [33:0] mHold [16];
  bit          mFlag [16];
  bit mBusy, mErr, modelLive;
  int mSlot;
  logic expV, expS, expE, expErr;
  logic [3:0]  expC;
  logic [33:0] expD;

  always @(posedge clk) begin
    bit busyPre, all, emit;
    bit flagPre [16];
    bit [4:0] freed;
    int ch, c;
    if (rst) begin
      for (int i = 0; i < 16; i++) begin mHold[i] = '0; mFlag[i] = 0; end
      mBusy = 0; mSlot = 0; mErr = 0;
      expV = 0; expS = 0; expE = 0; expC = '0; expD = '0;
    end else begin
      busyPre = mBusy;
      all = 1;
      for (int i = 0; i < 16; i++) begin
        flagPre[i] = mFlag[i];
        if (!mFlag[i]) all = 0;
      end
      emit = 0; ch = 0;
      if (!mBusy) begin
        if (all) begin emit = 1; ch = 0; mBusy = 1; mSlot = 1; end
      end else if (mSlot < 16) begin
        emit = 1; ch = mSlot; mSlot = mSlot + 1;
      end else begin
        mBusy = 0; mSlot = 0;
      end
      expV = emit; expS = emit && ch == 0; expE = emit && ch == 15;
      expC = emit ? 4'(ch) : 4'd0;
      expD = emit ? mHold[ch] : 34'd0;
      freed = '0;
      if (emit && ch == lastOfB(grpOfB(ch))) freed[grpOfB(ch)] = 1'b1;
      for (int i = 0; i < 16; i++) if (freed[grpOfB(i)]) mFlag[i] = 0;
      for (int g = 0; g < 5; g++) begin
        if ((g < 3 && nv[g]) || (g >= 3 && wv[g-3])) begin
          c = (g < 3) ? chOf(g, int'(nc[g])) : chOf(g, int'(wc[g-3]));
          if (busyPre && flagPre[c] && !freed[g]) mErr = 1;
          mHold[c] = (g < 3) ? {nd[g], 6'b0} : wd[g-3];
          mFlag[c] = 1;
        end
      end
    end
    expErr = mErr;
    modelLive = 1;
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (modelLive) begin
      vecCount++;
      if (outValid !== expV || outSop !== expS || outEop !== expE) begin
        vecFail++;
        $display("FAIL R5 framing v/s/e actual=%b%b%b expected=%b%b%b", outValid, outSop, outEop, expV, expS, expE);
      end else if (outChan !== expC) begin
        vecFail++;
        $display("FAIL R4 channel actual=%0d expected=%0d", outChan, expC);
      end else if (outData !== expD) begin
        vecFail++;
        if (expC < 12 && outData[5:0] != 6'd0)
          $display("FAIL R6 padding actual=%h expected=%h", outData, expD);
        else
          $display("FAIL R2 data ch%0d actual=%h expected=%h", expC, outData, expD);
      end else if (overlapErr !== expErr) begin
        vecFail++;
        $display("FAIL R8 overlapErr actual=%b expected=%b", overlapErr, expErr);
      end
      if (outValid === 1'b1) begin
        seenData[outChan] = outData;
        validSeen++;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    dirCount++;
    if (act !== exp) begin
      dirFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendGrp(int g, int c, logic [33:0] d);
    if (g < 3) begin nv[g] = 1'b1; nc[g] = 2'(c); nd[g] = d[27:0]; end
    else begin wv[g-3] = 1'b1; wc[g-3] = 1'(c); wd[g-3] = d; end
    @(negedge clk);
    if (g < 3) nv[g] = 1'b0; else wv[g-3] = 1'b0;
  endtask

  task automatic sendAllOf(int g, int pkt, bit rev);
    int n = (g < 3) ? 4 : 2;
    for (int k = 0; k < n; k++) begin
      int c = rev ? n - 1 - k : k;
      sendGrp(g, c, pat(pkt, chOf(g, c)));
    end
  endtask

  task automatic fillAll(int pkt, int sk, bit rev);
    for (int g = 0; g < 5; g++) begin
      automatic int gg = g;
      fork
        begin
          repeat ((gg * sk) % 5) @(negedge clk);
          sendAllOf(gg, pkt, rev);
        end
      join_none
    end
    wait fork;
  endtask

  task automatic waitChan(int c);
    do @(negedge clk); while (!(outValid === 1'b1 && outChan == 4'(c)));
  endtask

  task automatic waitEop();
    do @(negedge clk); while (outEop !== 1'b1);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary(int extra);
    $display("== %0d vectors applied, %0d miscompares ==",
             vecCount + dirCount, vecFail + dirFail + extra);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog R3 actual=running expected=finished");
    summary(1);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    chk("R1 outValid in reset", 64'(outValid), 64'd0);
    chk("R1 outData in reset", 64'(outData), 64'd0);
    chk("R1 overlapErr in reset", 64'(overlapErr), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R3: fifteen channels present, last one withheld
    for (int g = 0; g < 4; g++) begin
      automatic int gg = g;
      fork sendAllOf(gg, 1, 0); join_none
    end
    fork sendGrp(4, 0, pat(1, 14)); join_none
    wait fork;
    base = validSeen;
    repeat (20) @(negedge clk);
    chk("R3 no output while a channel is missing", 64'(validSeen - base), 64'd0);
    sendGrp(4, 1, pat(1, 15));
    chk("R3 not yet valid after capture edge", 64'(outValid), 64'd0);
    @(negedge clk);
    chk("R3 valid on second edge", 64'(outValid), 64'd1);
    chk("R3 sop on first word", 64'(outSop), 64'd1);
    waitEop();
    for (int ch = 0; ch < 12; ch++)
      chk("R6 narrow low bits zero", 64'(seenData[ch][5:0]), 64'd0);
    chk("R2 wide channel 15 value", 64'(seenData[15]), 64'(expWord(1, 15)));

    // R2: skewed and reordered arrivals
    for (int p = 0; p < 3; p++) begin
      fillAll(10 + p, p + 1, p[0]);
      waitEop();
      chk("R2 narrow channel 6 value", 64'(seenData[6]), 64'(expWord(10 + p, 6)));
      chk("R2 wide channel 13 value", 64'(seenData[13]), 64'(expWord(10 + p, 13)));
    end

    // R10: repeated sample while idle, last one wins
    sendGrp(0, 1, pat(50, 99));
    sendGrp(0, 1, pat(51, 1));
    fork
      sendGrp(0, 0, pat(51, 0));
      sendAllOf(1, 51, 0);
      sendAllOf(2, 51, 1);
      sendAllOf(3, 51, 0);
      sendAllOf(4, 51, 0);
    join
    sendGrp(0, 2, pat(51, 2));
    sendGrp(0, 3, pat(51, 3));
    waitEop();
    chk("R10 last value emitted", 64'(seenData[1]), 64'(expWord(51, 1)));
    chk("R10 no error for idle repeat", 64'(overlapErr), 64'd0);

    // R7: each group refills from its release edge onward
    fillAll(60, 2, 0);
    for (int g = 0; g < 5; g++) begin
      automatic int gg = g;
      fork
        begin
          waitChan(lastOfB(gg) - 1);
          sendAllOf(gg, 100, 0);
        end
      join_none
    end
    wait fork;
    waitEop();
    for (int ch = 0; ch < 16; ch++)
      chk("R7 refilled value in next packet", 64'(seenData[ch]), 64'(expWord(100, ch)));
    chk("R7 no error for released refill", 64'(overlapErr), 64'd0);

    // R8: sample into a channel still waiting for emission
    fillAll(200, 3, 1);
    waitChan(5);
    chk("R8 error low before clash", 64'(overlapErr), 64'd0);
    sendGrp(1, 0, pat(201, 4));
    chk("R8 error raised after clash", 64'(overlapErr), 64'd1);
    waitEop();
    chk("R9 error held after packet", 64'(overlapErr), 64'd1);
    fillAll(300, 4, 0);
    waitEop();
    chk("R9 error held across clean packet", 64'(overlapErr), 64'd1);

    // R1/R9: reset clears error and discards partial arrivals
    sendAllOf(0, 400, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 reset clears error", 64'(overlapErr), 64'd0);
    chk("R1 reset clears valid", 64'(outValid), 64'd0);
    rst = 1'b0;
    fork
      sendAllOf(1, 401, 0);
      sendAllOf(2, 401, 0);
      sendAllOf(3, 401, 0);
      sendAllOf(4, 401, 0);
    join
    base = validSeen;
    repeat (25) @(negedge clk);
    chk("R1 pre-reset samples discarded", 64'(validSeen - base), 64'd0);

    summary(0);
    $finish;
  end
endmodule